// File: doc/BRIEF.md
# SAR Conversion Sequencer

This block is the digital controller of a 12-bit successive-approximation converter. It picks one conversion trigger from a software strobe and four external event lines, runs a fixed acquisition window, then resolves the result one bit per clock. On each trial clock it drives a trial code to an external capacitor DAC and reads back a single comparator decision. When the last bit is settled it writes a formatted result word and raises a one-cycle ready strobe.

The input mode is captured at the start of each conversion and sets the output coding. Single-ended and pseudo differential conversions give plain unsigned codes. Fully differential conversions give a sign-extended two's complement value, doubled, so that the word can be read directly as a signed integer. The channel select is captured at the same point and held for the whole conversion. The highest channel index is wired to the on-die temperature sensor and is handled like any other channel.

Software can ask for one conversion or for a back-to-back stream. A stream runs until the enable is cleared.

Top module: `sar_seq_ctrl`

## Requirements
- R1: After reset, busy, ready, result, dac_code and mux_sel are all zero.
- R2: cfg_trig_sel picks the start source. Value 0 means the sw_start level sampled on a clock edge. Values 1 to 4 mean a rising edge on ext_trig[0] to ext_trig[3], detected after a two-flop synchronizer. Values 5 to 7 never start a conversion, and a source that is not selected has no effect.
- R3: While cfg_enable is low, no conversion starts.
- R4: A trigger that arrives while busy is high is dropped. It produces no extra ready pulse.
- R5: After ACQ_CYCLES acquisition clocks, the first trial drives dac_code = 0x800. Bits are then tried MSB first, one per clock. A bit is kept when cmp_in is 1 in its trial cycle and cleared otherwise, so the code converges to the largest value the comparator accepts.
- R6: busy is high from the clock after a start through the last trial cycle. ready is a single-cycle pulse in the cycle after the last trial. result changes only in a ready cycle.
- R7: With cfg_mode 0 (single-ended), 1 (pseudo differential) or 3 (treated as single-ended), result is the 12-bit code zero-extended to 16 bits.
- R8: With cfg_mode 2 (fully differential), result is the 16-bit two's complement of 2 x (code - 2048). Bit 0 is therefore always 0, code 0 gives 0xF000 and code 4095 gives 0x0FFE.
- R9: If cfg_continuous and cfg_enable are both high at the last trial, the next acquisition starts in the ready cycle and busy stays high. Clearing cfg_enable lets the running conversion finish, after which busy falls.
- R10: mux_sel and the coding mode are captured from cfg_channel and cfg_mode when a conversion starts. mux_sel does not change while that conversion is busy.
- R11: One conversion occupies exactly ACQ_CYCLES + 12 busy cycles (16 with defaults), well under the 41-clock budget of a conversion at full rate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_enable | input | 1 | Allows conversions to start and to chain |
| cfg_continuous | input | 1 | 1 = back-to-back conversions, 0 = one per trigger |
| cfg_trig_sel | input | 3 | Start source: 0 software, 1..4 ext_trig[0..3] |
| cfg_mode | input | 2 | 0 single-ended, 1 pseudo differential, 2 fully differential, 3 as 0 |
| cfg_channel | input | 4 | Input channel to convert (15 = temperature sensor) |
| sw_start | input | 1 | Software start strobe |
| ext_trig | input | 4 | Asynchronous external start events |
| cmp_in | input | 1 | Comparator: 1 when the input is at or above the trial level |
| dac_code | output | 12 | Trial code to the capacitor DAC |
| mux_sel | output | 4 | Channel select held during a conversion |
| busy | output | 1 | Conversion in progress |
| result | output | 16 | Formatted result word |
| ready | output | 1 | One-cycle strobe when result updates |

## Verification
The embedded assertions check the following on every cycle:
- the first trial code is the MSB alone;
- ready never lasts two cycles;
- result holds outside ready cycles;
- a differential result has a clear bit 0;
- no start happens while disabled;
- mux_sel is stable inside a conversion;
- the busy length at the last trial is correct.

The bench scenarios cover what needs real stimulus and an analog model. These are convergence of the bit trials to the modelled input over the whole code range, the exact coding values in each mode, selection and masking of each trigger source through the synchronizer, trigger dropping while busy, and the stop of a continuous stream after the enable is cleared.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;

  typedef enum logic [1:0] {
    MODE_SE  = 2'd0,
    MODE_PD  = 2'd1,
    MODE_FD  = 2'd2,
    MODE_RSV = 2'd3
  } in_mode_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ACQ   = 2'd1,
    ST_TRIAL = 2'd2
  } sar_state_e;

endpackage

// File: rtl/sar_trig_sync.sv
module sar_trig_sync #(
  parameter int NUM_EXT = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_EXT-1:0] async_in,
  output logic [NUM_EXT-1:0] rise_o
);

  // per line: two synchronizer flops plus one history flop for edge detect
  for (genvar g = 0; g < NUM_EXT; g++) begin : g_line
    logic [2:0] sh;
    always_ff @(posedge clk) begin
      if (rst) begin
        sh        <= '0;
        rise_o[g] <= 1'b0;
      end else begin
        sh        <= {sh[1:0], async_in[g]};
        rise_o[g] <= sh[1] & ~sh[2];
      end
    end
  end

endmodule

// File: rtl/sar_bit_engine.sv
module sar_bit_engine
  import sar_seq_pkg::*;
#(
  parameter int RES_BITS   = 12,
  parameter int ACQ_CYCLES = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                start,
  input  logic                chain,
  input  logic                cmp_in,
  output logic                busy,
  output logic                last_trial,
  output logic [RES_BITS-1:0] dac_code,
  output logic [RES_BITS-1:0] final_code
);

  localparam int ACQ_W = (ACQ_CYCLES > 1) ? $clog2(ACQ_CYCLES + 1) : 1;
  localparam int IDX_W = $clog2(RES_BITS);
  localparam logic [RES_BITS-1:0] MSB_ONLY = {1'b1, {(RES_BITS-1){1'b0}}};

  sar_state_e          state;
  logic [ACQ_W-1:0]    acq_cnt;
  logic [IDX_W-1:0]    idx;
  logic [RES_BITS-1:0] cur_mask;
  logic [RES_BITS-1:0] kept_code;

  always_comb begin
    cur_mask   = {{(RES_BITS-1){1'b0}}, 1'b1} << idx;
    kept_code  = cmp_in ? dac_code : (dac_code & ~cur_mask);
    last_trial = (state == ST_TRIAL) && (idx == '0);
    final_code = kept_code;
  end

  assign busy = (state != ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      acq_cnt  <= '0;
      idx      <= '0;
      dac_code <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (start) begin
            state   <= ST_ACQ;
            acq_cnt <= '0;
          end
        end
        ST_ACQ: begin
          if (acq_cnt == ACQ_W'(ACQ_CYCLES - 1)) begin
            state    <= ST_TRIAL;
            idx      <= IDX_W'(RES_BITS - 1);
            dac_code <= MSB_ONLY;
          end else begin
            acq_cnt <= acq_cnt + 1'b1;
          end
        end
        ST_TRIAL: begin
          if (idx == '0) begin
            dac_code <= '0;
            acq_cnt  <= '0;
            state    <= chain ? ST_ACQ : ST_IDLE;
          end else begin
            dac_code <= kept_code | (cur_mask >> 1);
            idx      <= idx - 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R5: the first trial after acquisition presents only the top bit
  assert_first_trial_msb_R5: assert property (@(posedge clk) disable iff (rst)
    (state == ST_TRIAL && $past(state) == ST_ACQ) |-> (dac_code == MSB_ONLY));

  // R5: an idle engine drives no trial code
  assert_idle_dac_zero_R5: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE) |-> (dac_code == '0));

endmodule

// File: rtl/sar_result_fmt.sv
module sar_result_fmt
  import sar_seq_pkg::*;
#(
  parameter int RES_BITS = 12,
  parameter int WORD_W   = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                load,
  input  in_mode_e            mode,
  input  logic [RES_BITS-1:0] raw,
  output logic [WORD_W-1:0]   result,
  output logic                ready
);

  localparam int EXT_U = WORD_W - RES_BITS;
  localparam int EXT_S = WORD_W - RES_BITS - 1;

  logic [RES_BITS-1:0] tc;
  logic [WORD_W-1:0]   word_u;
  logic [WORD_W-1:0]   word_s;
  logic [WORD_W-1:0]   word_sel;

  always_comb begin
    tc       = {~raw[RES_BITS-1], raw[RES_BITS-2:0]};
    word_u   = {{EXT_U{1'b0}}, raw};
    word_s   = {{EXT_S{tc[RES_BITS-1]}}, tc, 1'b0};
    word_sel = (mode == MODE_FD) ? word_s : word_u;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      result <= '0;
      ready  <= 1'b0;
    end else begin
      ready <= load;
      if (load) result <= word_sel;
    end
  end

  // R6: ready is a single-cycle strobe
  assert_ready_single_R6: assert property (@(posedge clk) disable iff (rst)
    ready |=> !ready);

  // R6: the result word holds outside ready cycles
  assert_result_hold_R6: assert property (@(posedge clk) disable iff (rst)
    !ready |-> $stable(result));

  // R8: differential results are even and arrive with ready
  assert_fd_lsb_clear_R8: assert property (@(posedge clk) disable iff (rst)
    (load && mode == MODE_FD) |=> (ready && !result[0]));

endmodule

// File: rtl/sar_seq_ctrl.sv
module sar_seq_ctrl
  import sar_seq_pkg::*;
#(
  parameter int RES_BITS   = 12,
  parameter int ACQ_CYCLES = 4,
  parameter int NUM_EXT    = 4,
  parameter int CHAN_W     = 4,
  parameter int WORD_W     = 16,
  localparam int TSEL_W    = $clog2(NUM_EXT + 1)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                cfg_enable,
  input  logic                cfg_continuous,
  input  logic [TSEL_W-1:0]   cfg_trig_sel,
  input  logic [1:0]          cfg_mode,
  input  logic [CHAN_W-1:0]   cfg_channel,
  input  logic                sw_start,
  input  logic [NUM_EXT-1:0]  ext_trig,
  input  logic                cmp_in,
  output logic [RES_BITS-1:0] dac_code,
  output logic [CHAN_W-1:0]   mux_sel,
  output logic                busy,
  output logic [WORD_W-1:0]   result,
  output logic                ready
);

  localparam int LEN_W = $clog2(ACQ_CYCLES + RES_BITS + 2);

  logic [NUM_EXT-1:0]  ext_rise;
  logic                trig_evt;
  logic                start_go;
  logic                chain_ok;
  logic                chain_go;
  logic                last_trial;
  logic [RES_BITS-1:0] final_code;
  in_mode_e            mode_q;
  logic [LEN_W-1:0]    len_cnt;

  sar_trig_sync #(.NUM_EXT(NUM_EXT)) u_sync (
    .clk      (clk),
    .rst      (rst),
    .async_in (ext_trig),
    .rise_o   (ext_rise)
  );

  always_comb begin
    trig_evt = 1'b0;
    if (cfg_trig_sel == '0) trig_evt = sw_start;
    for (int i = 0; i < NUM_EXT; i++) begin
      if (cfg_trig_sel == TSEL_W'(i + 1)) trig_evt = ext_rise[i];
    end
  end

  assign start_go = cfg_enable && !busy && trig_evt;
  assign chain_ok = cfg_enable && cfg_continuous;
  assign chain_go = last_trial && chain_ok;

  sar_bit_engine #(.RES_BITS(RES_BITS), .ACQ_CYCLES(ACQ_CYCLES)) u_engine (
    .clk        (clk),
    .rst        (rst),
    .start      (start_go),
    .chain      (chain_ok),
    .cmp_in     (cmp_in),
    .busy       (busy),
    .last_trial (last_trial),
    .dac_code   (dac_code),
    .final_code (final_code)
  );

  // channel and coding mode are captured at each conversion start
  always_ff @(posedge clk) begin
    if (rst) begin
      mux_sel <= '0;
      mode_q  <= MODE_SE;
    end else if (start_go || chain_go) begin
      mux_sel <= cfg_channel;
      mode_q  <= in_mode_e'(cfg_mode);
    end
  end

  sar_result_fmt #(.RES_BITS(RES_BITS), .WORD_W(WORD_W)) u_fmt (
    .clk    (clk),
    .rst    (rst),
    .load   (last_trial),
    .mode   (mode_q),
    .raw    (final_code),
    .result (result),
    .ready  (ready)
  );

  // conversion length counter, used only by the check below
  always_ff @(posedge clk) begin
    if (rst) len_cnt <= '0;
    else if (start_go || chain_go) len_cnt <= '0;
    else if (len_cnt != '1) len_cnt <= len_cnt + 1'b1;
  end

  // R11: the last trial falls exactly ACQ_CYCLES + RES_BITS - 1 cycles after a start
  assert_conv_length_R11: assert property (@(posedge clk) disable iff (rst)
    last_trial |-> (len_cnt == LEN_W'(ACQ_CYCLES + RES_BITS - 1)));

  // R3: a conversion begins only when enabled
  assert_start_needs_enable_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(cfg_enable));

  // R10: the channel select holds inside a conversion
  assert_mux_stable_R10: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy) && !ready) |-> $stable(mux_sel));

endmodule

// File: tb/sar_seq_ctrl_tb.sv
module sar_seq_ctrl_tb_top;

  localparam int ACQ = 4;

  logic        clk = 1'b0;
  logic        rst;
  logic        cfg_enable;
  logic        cfg_continuous;
  logic [2:0]  cfg_trig_sel;
  logic [1:0]  cfg_mode;
  logic [3:0]  cfg_channel;
  logic        sw_start;
  logic [3:0]  ext_trig;
  logic        cmp_in;
  logic [11:0] dac_code;
  logic [3:0]  mux_sel;
  logic        busy;
  logic [15:0] result;
  logic        ready;
  logic [11:0] vin;

  int n_tests = 0;
  int n_fail  = 0;
  bit ended   = 0;

  always #5 clk = ~clk;

  // comparator model: input at or above the trial level
  assign cmp_in = (vin >= dac_code);

  sar_seq_ctrl dut_i (
    .clk(clk), .rst(rst), .cfg_enable(cfg_enable), .cfg_continuous(cfg_continuous),
    .cfg_trig_sel(cfg_trig_sel), .cfg_mode(cfg_mode), .cfg_channel(cfg_channel),
    .sw_start(sw_start), .ext_trig(ext_trig), .cmp_in(cmp_in), .dac_code(dac_code),
    .mux_sel(mux_sel), .busy(busy), .result(result), .ready(ready)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] exp_word(input int m, input int v);
    if (m == 2) return 16'(2 * (v - 2048));
    return 16'(v);
  endfunction

  task automatic pulse_sw();
    sw_start = 1'b1;
    @(negedge clk);
    sw_start = 1'b0;
  endtask

  task automatic pulse_ext(input int line);
    ext_trig[line] = 1'b1;
    repeat (2) @(negedge clk);
    ext_trig[line] = 1'b0;
  endtask

  task automatic watch(input int ncyc, output int nready);
    nready = 0;
    for (int c = 0; c < ncyc; c++) begin
      @(negedge clk);
      if (ready) nready++;
    end
  endtask

  task automatic wait_ready(output bit got);
    got = 0;
    for (int c = 0; c < 100; c++) begin
      @(negedge clk);
      if (ready) begin got = 1; break; end
    end
  endtask

  // one software-started conversion with timing checks
  task automatic conv_once(input int m, input int v, input string req);
    int bcount;
    int first_trial;
    cfg_mode = 2'(m); vin = 12'(v);
    cfg_continuous = 0; cfg_enable = 1; cfg_trig_sel = 0;
    pulse_sw();
    bcount = busy ? 1 : 0;
    first_trial = -1;
    for (int c = 0; c < 100; c++) begin
      if (bcount == ACQ + 1 && first_trial < 0) first_trial = int'(dac_code);
      @(negedge clk);
      if (ready) break;
      if (busy) bcount++;
    end
    check(result == exp_word(m, v), req, int'(result), int'(exp_word(m, v)));
    check(bcount == ACQ + 12, "R11 busy length", bcount, ACQ + 12);
    check(first_trial == 12'h800, "R5 first trial code", first_trial, 12'h800);
    check(!busy && ready, "R6 busy low in ready cycle", int'(busy), 0);
  endtask

  // continuous sweep over the code range
  task automatic sweep(input int m, input int step, input string req);
    int n;
    bit got;
    int v;
    n = (4095 + step - 1) / step + 1;
    cfg_mode = 2'(m); vin = 0;
    cfg_continuous = 1; cfg_enable = 1; cfg_trig_sel = 0;
    pulse_sw();
    for (int k = 0; k < n; k++) begin
      v = (k * step > 4095) ? 4095 : k * step;
      wait_ready(got);
      check(got && result == exp_word(m, v), req, int'(result), int'(exp_word(m, v)));
      if (k == n / 2) check(busy == 1'b1, "R9 busy stays high while chained", int'(busy), 1);
      if (k + 1 < n) begin
        vin = 12'(((k + 1) * step > 4095) ? 4095 : (k + 1) * step);
        if (k + 1 == n - 1) cfg_enable = 0;
      end
    end
    check(busy == 1'b0, "R9 stream stops after enable cleared", int'(busy), 0);
    cfg_continuous = 0; cfg_enable = 1;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    #(10 * 200000);
    if (!ended) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    int nr;
    rst = 1; cfg_enable = 0; cfg_continuous = 0; cfg_trig_sel = 0;
    cfg_mode = 0; cfg_channel = 0; sw_start = 0; ext_trig = 0; vin = 0;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    check(busy == 0 && ready == 0, "R1 busy/ready", {busy, ready}, 0);
    check(result == 0, "R1 result", int'(result), 0);
    check(dac_code == 0 && mux_sel == 0, "R1 dac/mux", {dac_code, mux_sel}, 0);

    // R5 R6 R7 R8 R11 single conversions
    conv_once(0, 1234, "R7 single-ended code");
    conv_once(1, 0, "R7 pseudo differential zero");
    conv_once(1, 4095, "R7 pseudo differential full scale");
    conv_once(3, 2048, "R7 reserved mode as single-ended");
    conv_once(2, 0, "R8 differential negative full scale");
    conv_once(2, 4095, "R8 differential positive full scale");
    conv_once(2, 2048, "R8 differential zero");
    conv_once(2, 2047, "R8 differential minus one");

    // R3 enable low blocks software start
    cfg_enable = 0; cfg_trig_sel = 0;
    pulse_sw(); watch(40, nr);
    check(nr == 0, "R3 no conversion while disabled", nr, 0);
    cfg_enable = 1;

    // R2 each external source starts a conversion
    vin = 12'd777; cfg_mode = 0;
    for (int i = 0; i < 4; i++) begin
      cfg_trig_sel = 3'(i + 1);
      pulse_ext(i); watch(40, nr);
      check(nr == 1 && result == 16'd777, "R2 external source starts", nr, 1);
    end
    // R2 unselected source and sw while external selected are ignored
    cfg_trig_sel = 3'd1;
    pulse_ext(2); pulse_sw(); watch(40, nr);
    check(nr == 0, "R2 unselected sources ignored", nr, 0);
    // R2 values 5..7 never start
    for (int s = 5; s < 8; s++) begin
      cfg_trig_sel = 3'(s);
      ext_trig = 4'hF; repeat (2) @(negedge clk); ext_trig = 0;
      pulse_sw(); watch(40, nr);
      check(nr == 0, "R2 reserved select never starts", nr, 0);
    end

    // R4 triggers while busy are dropped
    cfg_trig_sel = 0;
    pulse_sw(); repeat (3) @(negedge clk); pulse_sw(); watch(60, nr);
    check(nr == 1, "R4 software retrigger while busy", nr, 1);
    cfg_trig_sel = 3'd1;
    pulse_ext(0); repeat (6) @(negedge clk); pulse_ext(0); watch(60, nr);
    check(nr == 1, "R4 external retrigger while busy", nr, 1);

    // R10 channel captured at start and held
    cfg_trig_sel = 0; cfg_channel = 4'd5;
    pulse_sw(); repeat (3) @(negedge clk);
    cfg_channel = 4'd15;
    @(negedge clk);
    check(mux_sel == 4'd5, "R10 mux held while busy", int'(mux_sel), 5);
    watch(30, nr);
    check(mux_sel == 4'd5, "R10 mux after conversion", int'(mux_sel), 5);
    pulse_sw();
    check(mux_sel == 4'd15, "R10 temperature channel captured", int'(mux_sel), 15);
    watch(30, nr);

    // R5 R7 exhaustive single-ended sweep; R8 R9 differential sweep
    sweep(0, 1, "R5 single-ended sweep");
    sweep(2, 7, "R8 differential sweep");

    ended = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule